// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block sits beside the program counter in the fetch stage and proposes the next fetch address every cycle. It holds a small, fully associative table in which each entry pairs a branch instruction address (the tag) with the target that branch last jumped to. The current fetch address is compared with every valid tag within the same cycle. When an entry matches, its stored target is offered as the next fetch address and the hit flag is raised. When nothing matches, the block offers the fetch address advanced by one instruction.

When a branch resolves later in the pipeline, the update port reports the branch address, the target it actually used and whether it was taken. A taken branch is recorded, so the next fetch of that address is steered to the same target. For a loop-closing branch, the prediction is therefore wrong only on the first and the last pass. A branch that falls through removes its entry. A flush input clears the whole table. The block keeps no direction counters: any hit is treated as a taken redirect.

Top module: `btb_predictor`

## Requirements
- R1: After reset no entry is valid: `hit` is 0 and `next_pc` equals `fetch_pc + 4` for any fetch address.
- R2: When a valid entry's tag equals `fetch_pc`, `hit` is 1 and `next_pc` equals that entry's target in the same cycle, with no register in the lookup path.
- R3: When no valid entry's tag equals `fetch_pc`, `hit` is 0 and `next_pc` equals `fetch_pc + 4`, wrapping modulo 2^32.
- R4: An update with `upd_valid`=1 and `upd_taken`=1 records the pair (`upd_pc`, `upd_target`). A lookup of `upd_pc` on any later cycle hits with that target until the entry is removed.
- R5: A taken update whose `upd_pc` is already present replaces only that entry's target and takes no further slot. Every other entry stays resident.
- R6: A taken update of an address not present fills slots in strict rotation, one step per new address. The ninth distinct address evicts the first one recorded, while the second through eighth still hit.
- R7: An update with `upd_valid`=1 and `upd_taken`=0 invalidates the entry matching `upd_pc`, if there is one. If there is none, every resident entry still hits afterwards.
- R8: `flush_all`=1 invalidates every entry from the next cycle on. A taken update presented in the same cycle is discarded.
- R9: A lookup and an update of the same address in one cycle see the table as it was before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | Current fetch address |
| upd_valid | input | 1 | Resolved-branch update strobe |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Target the resolved branch used |
| upd_taken | input | 1 | 1 = branch taken (record), 0 = fell through (remove) |
| flush_all | input | 1 | Invalidate the whole table |
| next_pc | output | 32 | Predicted next fetch address |
| hit | output | 1 | A valid entry matched `fetch_pc` |

## Verification
Two functions can meet in one cycle: the combinational lookup and the registered table update. The bench drives `fetch_pc` equal to `upd_pc` during taken updates, during not-taken updates and during overwrites of an existing target. It expects the pre-update contents in that cycle (a miss, or the old target) and the new contents one cycle later. Flush is also raised together with a taken update, and the bench confirms that the address is absent on the following cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;
  parameter int BTB_ADDR_W = 32;

  typedef struct packed {
    logic                  valid;
    logic [BTB_ADDR_W-1:0] tag;
    logic [BTB_ADDR_W-1:0] target;
  } btb_entry_t;
endpackage

// File: rtl/btb_match.sv
module btb_match
  import btb_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  btb_entry_t [ENTRIES-1:0]      ents,
  input  logic [BTB_ADDR_W-1:0]         addr,
  output logic [ENTRIES-1:0]            sel,
  output logic                          any
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign sel[i] = ents[i].valid && (ents[i].tag == addr);
  end

  assign any = |sel;

  // Update logic must never leave two valid entries with one tag (R5)
  assert_single_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  output logic [IDX_W-1:0] slot
);
  logic [IDX_W-1:0] slot_d;

  always_comb begin
    slot_d = slot;
    if (alloc) begin
      if (slot == IDX_W'(ENTRIES - 1)) slot_d = '0;
      else                             slot_d = slot + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     slot <= '0;
    else if (alloc) slot <= slot_d;
  end

  assert_rr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc |=> $stable(slot));
  assert_rr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= IDX_W'(ENTRIES - 1));
endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ENTRIES-1:0]        wr_en,
  input  logic [ENTRIES-1:0]        clr,
  input  logic [BTB_ADDR_W-1:0]     wr_tag,
  input  logic [BTB_ADDR_W-1:0]     wr_tgt,
  output btb_entry_t [ENTRIES-1:0]  ents
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    btb_entry_t ent_q;
    btb_entry_t ent_d;
    logic       ent_en;

    assign ent_en = clr[i] | wr_en[i];

    always_comb begin
      ent_d = ent_q;
      if (clr[i]) begin
        ent_d.valid = 1'b0;
      end else if (wr_en[i]) begin
        ent_d.valid  = 1'b1;
        ent_d.tag    = wr_tag;
        ent_d.target = wr_tgt;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_en) ent_q <= ent_d;
    end

    assign ents[i] = ent_q;

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] |=> !ent_q.valid);
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int STEP    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BTB_ADDR_W-1:0] fetch_pc,
  input  logic                  upd_valid,
  input  logic [BTB_ADDR_W-1:0] upd_pc,
  input  logic [BTB_ADDR_W-1:0] upd_target,
  input  logic                  upd_taken,
  input  logic                  flush_all,
  output logic [BTB_ADDR_W-1:0] next_pc,
  output logic                  hit
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  btb_entry_t [ENTRIES-1:0] ents;
  logic [ENTRIES-1:0]       look_sel;
  logic [ENTRIES-1:0]       upd_sel;
  logic                     upd_hit;
  logic [IDX_W-1:0]         victim;
  logic                     rec;
  logic                     alloc;
  logic [ENTRIES-1:0]       wr_en;
  logic [ENTRIES-1:0]       clr;
  logic [BTB_ADDR_W-1:0]    look_tgt;

  btb_match #(.ENTRIES(ENTRIES)) u_look (
    .clk(clk), .rst_n(rst_n), .ents(ents), .addr(fetch_pc),
    .sel(look_sel), .any(hit)
  );

  btb_match #(.ENTRIES(ENTRIES)) u_updm (
    .clk(clk), .rst_n(rst_n), .ents(ents), .addr(upd_pc),
    .sel(upd_sel), .any(upd_hit)
  );

  assign rec   = upd_valid && upd_taken && !flush_all;
  assign alloc = rec && !upd_hit;

  btb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .slot(victim)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ctl
    assign wr_en[i] = rec && (upd_hit ? upd_sel[i] : (victim == IDX_W'(i)));
    assign clr[i]   = flush_all || (upd_valid && !upd_taken && upd_sel[i]);
  end

  btb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .clr(clr),
    .wr_tag(upd_pc), .wr_tgt(upd_target), .ents(ents)
  );

  always_comb begin
    look_tgt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (look_sel[i]) look_tgt = look_tgt | ents[i].target;
    end
  end

  assign next_pc = hit ? look_tgt : (fetch_pc + BTB_ADDR_W'(STEP));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !hit);

  assert_record_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && !flush_all) |=>
      ((fetch_pc != $past(upd_pc)) || (hit && next_pc == $past(upd_target))));

  assert_drop_on_fallthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |=> ((fetch_pc != $past(upd_pc)) || !hit));
endmodule

// File: tb/btb_predictor_bench.sv
`timescale 1ns/1ps
module btb_predictor_bench;
  logic        clk;
  logic        rst_n;
  logic [31:0] fetch_pc;
  logic        upd_valid;
  logic [31:0] upd_pc;
  logic [31:0] upd_target;
  logic        upd_taken;
  logic        flush_all;
  logic [31:0] next_pc;
  logic        hit;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  bit          m_v [8];
  logic [31:0] m_tag [8];
  logic [31:0] m_tgt [8];
  int          m_alloc = 0;

  btb_predictor u_btb_predictor (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_target(upd_target), .upd_taken(upd_taken),
    .flush_all(flush_all), .next_pc(next_pc), .hit(hit)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic int m_find(input logic [31:0] a);
    for (int j = 0; j < 8; j++) if (m_v[j] && m_tag[j] == a) return j;
    return -1;
  endfunction

  task automatic step(input logic [31:0] pc, input bit uv, input logic [31:0] upc,
                      input logic [31:0] utgt, input bit utk, input bit fl,
                      input string req);
    int j;
    bit e_hit;
    logic [31:0] e_pc;
    @(negedge clk);
    fetch_pc = pc; upd_valid = uv; upd_pc = upc; upd_target = utgt;
    upd_taken = utk; flush_all = fl;
    #1;
    j = m_find(pc);
    e_hit = (j >= 0);
    e_pc  = e_hit ? m_tgt[j] : pc + 32'd4;
    n_checks++;
    if (hit !== e_hit || next_pc !== e_pc) begin
      n_fail++;
      $display("FAIL %s pc=%h: hit=%b next_pc=%h expected hit=%b next_pc=%h",
               req, pc, hit, next_pc, e_hit, e_pc);
    end
    if (fl) begin
      for (int k = 0; k < 8; k++) m_v[k] = 0;
    end else if (uv) begin
      j = m_find(upc);
      if (utk) begin
        if (j >= 0) m_tgt[j] = utgt;
        else begin
          m_v[m_alloc % 8] = 1; m_tag[m_alloc % 8] = upc; m_tgt[m_alloc % 8] = utgt;
          m_alloc++;
        end
      end else if (j >= 0) m_v[j] = 0;
    end
  endtask

  task automatic look(input logic [31:0] pc, input string req);
    step(pc, 0, 32'h0, 32'h0, 0, 0, req);
  endtask

  task automatic rec(input logic [31:0] pc, input logic [31:0] bpc,
                     input logic [31:0] tgt, input string req);
    step(pc, 1, bpc, tgt, 1, 0, req);
  endtask

  initial begin
    #150000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) begin m_v[k] = 0; m_tag[k] = 0; m_tgt[k] = 0; end
    rst_n = 0; fetch_pc = 0; upd_valid = 0; upd_pc = 0; upd_target = 0;
    upd_taken = 0; flush_all = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: empty table after reset
    look(32'h0000_0000, "R1");
    look(32'h0000_1000, "R1");
    // R3: sequential wrap
    look(32'hFFFF_FFFC, "R3");

    // R9 + R4: record while looking up the same address, then hit
    rec(32'h0000_0100, 32'h0000_0100, 32'h0000_0200, "R9");
    look(32'h0000_0100, "R4");
    // R2: lookup hits combinationally with a different update alongside
    rec(32'h0000_0100, 32'h0000_0300, 32'h0000_0040, "R2");
    look(32'h0000_0300, "R2");
    look(32'h0000_0104, "R3");

    // R5 + R9: overwrite target, old value in the update cycle
    rec(32'h0000_0100, 32'h0000_0100, 32'h0000_0280, "R9");
    look(32'h0000_0100, "R5");
    look(32'h0000_0300, "R5");

    // R7: fall-through removes, absent address leaves table intact
    step(32'h0000_0300, 1, 32'h0000_0300, 32'h0, 0, 0, "R9");
    look(32'h0000_0300, "R7");
    step(32'h0000_0100, 1, 32'h0000_0BAD, 32'h0, 0, 0, "R7");
    look(32'h0000_0100, "R7");

    // R8: flush with simultaneous taken update
    step(32'h0000_0100, 1, 32'h0000_0500, 32'h0000_0600, 1, 1, "R8");
    look(32'h0000_0100, "R8");
    look(32'h0000_0500, "R8");

    // R6: nine new addresses, the first is evicted
    for (int k = 0; k < 9; k++)
      rec(32'h0000_8000, 32'h0000_1000 + k * 16, 32'h0000_2000 + k * 4, "R6");
    for (int k = 0; k < 9; k++)
      look(32'h0000_1000 + k * 16, "R6");

    // R4 + R2: loop-closing branch taken repeatedly, then once not taken
    for (int it = 0; it < 5; it++) begin
      look(32'h0000_3040, "R2");
      rec(32'h0000_3020, 32'h0000_3040, 32'h0000_3000, "R4");
    end
    step(32'h0000_3040, 1, 32'h0000_3040, 32'h0, 0, 0, "R7");
    look(32'h0000_3040, "R7");
    look(32'h0000_1010, "R6");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule